// File: doc/BRIEF.md
# Queued-Command SPI Master

This block is an SPI bus master. Each word that software queues carries the data to shift and also the control for that frame: the chip-select line it targets and a flag that keeps that line asserted into the following frame. A multi-word transaction is queued as a run of words. Every word except the last has the flag set, so the select stays low across the whole run and is released only after the final frame.

The frame engine takes words from a transmit queue of parameterised depth. It shifts each word out at a programmable length of 1 to 16 bits, most or least significant bit first, in any of the four clock polarity and phase combinations. Each finished frame places exactly one word in a receive queue. To only read from a slave, software queues an all-zero word and collects the returned frame. A control register holds an enable bit, a stop bit, per-line inactive levels and one-shot queue-clear bits. A status register reports both queue fill counts, a running flag and a sticky misuse flag. The serial clock comes from a tick generator that counts `HALF_DIV` system clocks per half period.

Top module: `spi_cw_master`

## Requirements
- R1: After reset, CTRL reads 0x003F0702 (not enabled, stopped, frame size 7, all six inactive levels high). STAT reads 0, every chip-select pin is high and SCK is low.
- R2: A write to TXQ (address 2) queues data from bits [15:0], the select index from [18:16] and the continue flag from bit 31. STAT[7:0] gives the TX fill count, capped at 4. A write while the TX queue is full is dropped and sets the error flag STAT[17].
- R3: A read of RXQ (address 3) while the RX queue is empty leaves the queue unchanged and sets STAT[17]. The flag stays set until STAT is written with bit 17 high.
- R4: STAT[16] reads 1 exactly when CTRL[0] (enable) is 1 and CTRL[1] (stop) is 0. While it reads 0, no frame starts, SCK does not toggle and queued words stay queued.
- R5: The frame length is CTRL[11:8] plus one. Bits go out most significant first when CTRL[6] is 0 and least significant first when CTRL[6] is 1.
- R6: SCK idles at CTRL[4]. With CTRL[5]=0 both sides sample on the first edge of each bit. With CTRL[5]=1 data changes on the first edge and is sampled on the second.
- R7: Each frame, including one sent from an all-zero word, adds one RX word, read from RXQ[15:0], right-aligned with the upper bits zero. STAT[15:8] gives the RX fill count. No frame starts while the RX queue is full.
- R8: During a frame with select index n < 6, pin n is driven to the inverse of CTRL[16+n] and every other pin stays at its inactive level. An index of 6 or 7 asserts no pin, but the frame still runs.
- R9: A frame with the continue flag set leaves its select asserted into the next frame. A frame with the flag clear releases its select when it finishes.
- R10: Writing CTRL with bit 2 (or bit 3) set empties the TX (or RX) queue. Both bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RXQ) |
| reg_addr | input | 2 | Register index: 0 CTRL, 1 STAT, 2 TXQ, 3 RXQ |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_pin | output | NCS | Chip-select lines |

## Verification
The checks assume that reg_wr and reg_rd are never high in the same cycle. They also assume that the mode fields in CTRL are rewritten only while no frame is in flight and no select is held. The stimulus keeps within this: every register access is a single strobe issued away from the clock edge, and the frame settings are changed only after the previous frame's RX word has been seen. The slave model ties its MISO bit to the count of sampling edges it has seen, so that bit is stable whenever the master samples it.

// File: rtl/spi_cw_pkg.sv
package spi_cw_pkg;
  localparam int DATA_W = 16;
  localparam int CSI_W  = 3;
  localparam int LEN_W  = 4;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_TXQ  = 2'd2;
  localparam logic [1:0] A_RXQ  = 2'd3;

  typedef struct packed {
    logic              cont;
    logic [CSI_W-1:0]  cs;
    logic [DATA_W-1:0] data;
  } tx_entry_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} eng_state_t;
endpackage

// File: rtl/spi_cw_fifo.sv
module spi_cw_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem_q[rd_q];
  assign count   = cnt_q;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem_q[wr_q] <= wdata;
  end
endmodule

// File: rtl/spi_cw_tick.sv
module spi_cw_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CW'(HALF_DIV-1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_cw_engine.sv
module spi_cw_engine
  import spi_cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_ok,
  input  logic              tx_valid,
  input  tx_entry_t         tx_entry,
  input  logic              tick,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic [LEN_W-1:0]  fsize,
  input  logic              miso,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_word,
  output logic              run,
  output logic              sck,
  output logic              mosi,
  output logic              cs_on,
  output logic [CSI_W-1:0]  cs_sel,
  output logic              cont
);
  eng_state_t        st_q, st_d;
  logic [DATA_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic [LEN_W:0]    h_q, h_d;
  logic [LEN_W-1:0]  idx_q, idx_d, pos;
  logic              sck_q, sck_d, on_q, on_d, cont_q, cont_d;
  logic [CSI_W-1:0]  sel_q, sel_d;
  logic              lead, last;

  assign pos     = lsb_first ? idx_q : (fsize - idx_q);
  assign lead    = ~h_q[0];
  assign last    = (h_q == {fsize, 1'b1});
  assign mosi    = tx_q[pos];
  assign sck     = sck_q;
  assign cs_on   = on_q;
  assign cs_sel  = sel_q;
  assign cont    = cont_q;
  assign rx_word = rx_q;
  assign run     = (st_q != ST_IDLE);

  always_comb begin
    st_d    = st_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    h_d     = h_q;
    idx_d   = idx_q;
    sck_d   = sck_q;
    on_d    = on_q;
    sel_d   = sel_q;
    cont_d  = cont_q;
    tx_pop  = 1'b0;
    rx_push = 1'b0;
    case (st_q)
      ST_IDLE: begin
        sck_d = cpol;
        if (go_ok && tx_valid) begin
          tx_pop = 1'b1;
          tx_d   = tx_entry.data;
          sel_d  = tx_entry.cs;
          cont_d = tx_entry.cont;
          on_d   = 1'b1;
          h_d    = '0;
          idx_d  = '0;
          rx_d   = '0;
          st_d   = ST_LEAD;
        end
      end
      ST_LEAD: if (tick) st_d = ST_SHIFT;
      ST_SHIFT: if (tick) begin
        sck_d = ~sck_q;
        if (lead != cpha) rx_d[pos] = miso;
        if (!last && ((!cpha && !lead) || (cpha && lead && h_q != '0)))
          idx_d = idx_q + 1'b1;
        if (last) st_d = ST_TRAIL;
        else      h_d  = h_q + 1'b1;
      end
      ST_TRAIL: if (tick) begin
        rx_push = 1'b1;
        if (!cont_q) on_d = 1'b0;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tx_q   <= '0;
      rx_q   <= '0;
      h_q    <= '0;
      idx_q  <= '0;
      sck_q  <= 1'b0;
      on_q   <= 1'b0;
      sel_q  <= '0;
      cont_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      h_q    <= h_d;
      idx_q  <= idx_d;
      sck_q  <= sck_d;
      on_q   <= on_d;
      sel_q  <= sel_d;
      cont_q <= cont_d;
    end
  end
endmodule

// File: rtl/spi_cw_master.sv
module spi_cw_master
  import spi_cw_pkg::*;
#(
  parameter int NCS      = 6,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int HALF_DIV = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [1:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_pin
);
  localparam int TCW = $clog2(TX_DEPTH+1);
  localparam int RCW = $clog2(RX_DEPTH+1);

  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic             en_q, en_d, halt_q, halt_d, cpol_q, cpol_d;
  logic             cpha_q, cpha_d, lsb_q, lsb_d, err_q, err_d;
  logic [LEN_W-1:0] fsize_q, fsize_d;
  logic [NCS-1:0]   idle_q, idle_d;

  logic wr_ctrl, drop_tx, drop_rx, tx_wr, rx_rd, err_clr, running;
  logic tx_full, tx_empty, rx_full, rx_empty, tx_pop, rx_push, run, tick;
  logic cs_on, cont_q;
  logic [CSI_W-1:0]  cs_sel;
  logic [TCW-1:0]    tx_cnt;
  logic [RCW-1:0]    rx_cnt;
  logic [DATA_W-1:0] rx_word, rx_head;
  tx_entry_t         tx_in, tx_head;
  logic [5:0]        idle_ext;

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign drop_tx  = wr_ctrl && reg_wdata[2];
  assign drop_rx  = wr_ctrl && reg_wdata[3];
  assign tx_wr    = reg_wr && (reg_addr == A_TXQ);
  assign rx_rd    = reg_rd && (reg_addr == A_RXQ);
  assign err_clr  = reg_wr && (reg_addr == A_STAT) && reg_wdata[17];
  assign running  = en_q && !halt_q;
  assign tx_in    = '{cont: reg_wdata[31], cs: reg_wdata[18:16], data: reg_wdata[15:0]};
  assign idle_ext = 6'(idle_q);

  always_comb begin
    en_d    = en_q;
    halt_d  = halt_q;
    cpol_d  = cpol_q;
    cpha_d  = cpha_q;
    lsb_d   = lsb_q;
    fsize_d = fsize_q;
    idle_d  = idle_q;
    err_d   = err_q;
    if (wr_ctrl) begin
      en_d    = reg_wdata[0];
      halt_d  = reg_wdata[1];
      cpol_d  = reg_wdata[4];
      cpha_d  = reg_wdata[5];
      lsb_d   = reg_wdata[6];
      fsize_d = reg_wdata[11:8];
      idle_d  = reg_wdata[16 +: NCS];
    end
    if (err_clr) err_d = 1'b0;
    if ((tx_wr && tx_full) || (rx_rd && rx_empty)) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      en_q    <= 1'b0;
      halt_q  <= 1'b1;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      lsb_q   <= 1'b0;
      fsize_q <= LEN_W'(7);
      idle_q  <= '1;
      err_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      halt_q  <= halt_d;
      cpol_q  <= cpol_d;
      cpha_q  <= cpha_d;
      lsb_q   <= lsb_d;
      fsize_q <= fsize_d;
      idle_q  <= idle_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {10'b0, idle_ext, 4'b0, fsize_q, 1'b0, lsb_q, cpha_q, cpol_q, 2'b00, halt_q, en_q};
      A_STAT:  reg_rdata = {13'b0, (run || cs_on), err_q, running, 8'(rx_cnt), 8'(tx_cnt)};
      A_RXQ:   reg_rdata = {16'b0, rx_head};
      default: reg_rdata = '0;
    endcase
  end

  spi_cw_fifo #(.W($bits(tx_entry_t)), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_s), .flush(drop_tx), .push(tx_wr), .wdata(tx_in),
    .pop(tx_pop), .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spi_cw_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_s), .flush(drop_rx), .push(rx_push), .wdata(rx_word),
    .pop(rx_rd), .rdata(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  spi_cw_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_s), .run(run), .tick(tick));

  spi_cw_engine u_eng (
    .clk(clk), .rst_n(rst_s), .go_ok(running && !rx_full), .tx_valid(!tx_empty),
    .tx_entry(tx_head), .tick(tick), .cpol(cpol_q), .cpha(cpha_q), .lsb_first(lsb_q),
    .fsize(fsize_q), .miso(miso), .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
    .run(run), .sck(sck), .mosi(mosi), .cs_on(cs_on), .cs_sel(cs_sel), .cont(cont_q));

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_pin[i] = idle_q[i] ^ (cs_on && (cs_sel == CSI_W'(i)));
  end
endmodule

// File: rtl/spi_cw_checks.sv
module spi_cw_checks #(
  parameter int NCS      = 6,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NCS-1:0]                  cs_pin,
  input logic [NCS-1:0]                  idle_q,
  input logic                            running,
  input logic                            drop_tx,
  input logic [$clog2(TX_DEPTH+1)-1:0]   tx_cnt,
  input logic [$clog2(RX_DEPTH+1)-1:0]   rx_cnt,
  input logic                            rx_push,
  input logic                            cont_q,
  input logic [2:0]                      cs_sel,
  input logic                            err,
  input logic                            err_clr
);
  a_r2_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= ($clog2(TX_DEPTH+1))'(TX_DEPTH));

  a_r8_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_pin ^ idle_q));

  a_r4_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !drop_tx) |=> (tx_cnt >= $past(tx_cnt)));

  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && cont_q && (32'(cs_sel) < NCS)) |=> (cs_pin != idle_q));

  a_r7_rx_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt > $past(rx_cnt)) |-> $past(rx_push));
endmodule

bind spi_cw_master spi_cw_checks #(.NCS(NCS), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_s), .cs_pin(cs_pin), .idle_q(idle_q), .running(running),
  .drop_tx(drop_tx), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .rx_push(rx_push),
  .cont_q(cont_q), .cs_sel(cs_sel), .err(err_q), .err_clr(err_clr));

// File: tb/spi_cw_master_tb.sv
module spi_cw_master_tb_top;
  logic        clk, rst_n, reg_wr, reg_rd, sck, mosi, miso;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [5:0]  cs_pin;

  spi_cw_master dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck),
    .mosi(mosi), .miso(miso), .cs_pin(cs_pin));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, sck_tog = 0, sample_cnt = 0, releases = 0;
  bit done = 0, cap_en = 0, prev_act = 0;
  bit b_cpol = 0, b_cpha = 0, b_lsb = 0;
  int b_len = 8;
  logic [5:0]  b_idle = 6'h3F, act_seen;
  logic [15:0] slave_word = 16'h0;
  logic [15:0] cap [8];

  // slave model: output bit chosen by count of sampling edges seen
  always_comb begin
    int k;
    k = sample_cnt % b_len;
    miso = slave_word[b_lsb ? k : (b_len - 1 - k)];
  end

  always @(sck) begin
    sck_tog++;
    if (cap_en && sck == (b_cpol ^ !b_cpha)) begin
      int k, fr;
      k = sample_cnt % b_len;
      fr = sample_cnt / b_len;
      if (fr < 8) cap[fr][b_lsb ? k : (b_len - 1 - k)] = mosi;
      act_seen |= cs_pin ^ b_idle;
      sample_cnt++;
    end
  end

  always @(negedge clk) begin
    bit a;
    a = |(cs_pin ^ b_idle);
    if (prev_act && !a) releases++;
    prev_act = a;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  bit c_en = 0, c_halt = 1;
  int c_fs = 7;

  function automatic logic [31:0] ctrl_w(bit dtx, bit drx);
    return 32'(c_en) | (32'(c_halt) << 1) | (32'(dtx) << 2) | (32'(drx) << 3) |
           (32'(b_cpol) << 4) | (32'(b_cpha) << 5) | (32'(b_lsb) << 6) |
           (32'(c_fs) << 8) | (32'(b_idle) << 16);
  endfunction

  task automatic cfg(bit en, bit halt, bit cpol, bit cpha, bit lsb, int fs, logic [5:0] idle);
    cap_en = 0;
    c_en = en; c_halt = halt; b_cpol = cpol; b_cpha = cpha; b_lsb = lsb;
    c_fs = fs; b_len = fs + 1; b_idle = idle;
    wr(2'd0, ctrl_w(0, 0));
    repeat (3) @(posedge clk);
  endtask

  task automatic arm(logic [15:0] sw);
    slave_word = sw; sample_cnt = 0; act_seen = '0; releases = 0;
    for (int i = 0; i < 8; i++) cap[i] = '0;
    cap_en = 1;
  endtask

  task automatic wait_rx(int n);
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(2'd1, s);
      if (32'(s[15:8]) == n) break;
    end
  endtask

  function automatic logic [15:0] mask(int len);
    return 16'((32'h1 << len) - 1);
  endfunction

  task automatic push(int cs, logic [15:0] d, bit cont);
    wr(2'd2, (32'(cont) << 31) | (32'(cs) << 16) | 32'(d));
  endtask

  // one frame end to end; tag names the requirement under test
  task automatic one_frame(string tag, int cs, logic [15:0] d, logic [15:0] sw);
    logic [31:0] v;
    arm(sw);
    push(cs, d, 0);
    wait_rx(1);
    chk({tag, " mosi word"}, 32'(cap[0]), 32'(d & mask(b_len)));
    rd(2'd3, v);
    chk({tag, " R7 rx word"}, v, 32'(sw & mask(b_len)));
    chk({tag, " R8 line"}, 32'(act_seen), (cs < 6) ? (32'h1 << cs) : 32'h0);
    chk({tag, " R9 release"}, releases, (cs < 6) ? 1 : 0);
  endtask

  initial begin
    logic [31:0] v;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    void'($urandom(32'd1234));
    rst_n = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 32'h003F0702);
    rd(2'd1, v); chk("R1 stat", v, 32'h0);
    chk("R1 cs pins", 32'(cs_pin), 32'h3F);
    chk("R1 sck", 32'(sck), 32'h0);

    // R2/R4: enabled but stopped; overfill TX
    cfg(1, 1, 0, 0, 0, 7, 6'h3F);
    sck_tog = 0;
    for (int i = 0; i < 5; i++) push(1, 16'(i), 0);
    repeat (100) @(posedge clk);
    rd(2'd1, v);
    chk("R2 tx count capped", 32'(v[7:0]), 4);
    chk("R2 overflow err", 32'(v[17]), 1);
    chk("R4 running clear", 32'(v[16]), 0);
    chk("R4 no frame rx", 32'(v[15:8]), 0);
    chk("R4 sck quiet", sck_tog, 0);

    // R3 clear error, R10 flush TX
    wr(2'd1, 32'h0002_0000);
    rd(2'd1, v); chk("R3 err cleared", 32'(v[17]), 0);
    wr(2'd0, ctrl_w(1, 0));
    rd(2'd1, v); chk("R10 tx flushed", 32'(v[7:0]), 0);
    rd(2'd0, v); chk("R10 flush bits read 0", 32'(v[3:2]), 0);

    // R3 pop of empty RX
    rd(2'd3, v);
    rd(2'd1, v);
    chk("R3 underflow err", 32'(v[17]), 1);
    chk("R3 rx unchanged", 32'(v[15:8]), 0);
    repeat (5) @(posedge clk);
    rd(2'd1, v); chk("R3 err sticky", 32'(v[17]), 1);
    wr(2'd1, 32'h0002_0000);

    // R4 running, R5/R6 mode 0 msb 8 bit
    cfg(1, 0, 0, 0, 0, 7, 6'h3F);
    rd(2'd1, v); chk("R4 running set", 32'(v[16]), 1);
    one_frame("R5 R6 mode0", 2, 16'h00A5, 16'h003C);
    cfg(1, 0, 1, 1, 1, 11, 6'h3F);
    chk("R6 sck idles at cpol", 32'(sck), 1);
    one_frame("R5 R6 mode3 lsb", 5, 16'h0B37, 16'h0C91);
    cfg(1, 0, 0, 1, 0, 15, 6'h3F);
    one_frame("R7 read-only", 0, 16'h0000, 16'hBEEF);

    // R8 inverted inactive level on line 1, out-of-range index
    cfg(1, 0, 1, 0, 0, 7, 6'h3D);
    chk("R8 idle low line", 32'(cs_pin), 32'h3D);
    one_frame("R8 low idle", 1, 16'h005A, 16'h00C3);
    cfg(1, 0, 0, 0, 0, 7, 6'h3F);
    one_frame("R8 no line", 7, 16'h0011, 16'h0077);

    // R9 continued transaction, three 16-bit words on line 4
    cfg(1, 0, 0, 0, 0, 15, 6'h3F);
    arm(16'h5AA5);
    push(4, 16'h1234, 1); push(4, 16'hABCD, 1); push(4, 16'h0F0F, 0);
    wait_rx(3);
    chk("R9 single release", releases, 1);
    chk("R9 w0", 32'(cap[0]), 32'h1234);
    chk("R9 w1", 32'(cap[1]), 32'hABCD);
    chk("R9 w2", 32'(cap[2]), 32'h0F0F);
    for (int i = 0; i < 3; i++) begin
      rd(2'd3, v); chk("R9 R7 rx", v, 32'h5AA5);
    end

    // R7 stall on full RX, R10 flush RX
    cfg(1, 0, 0, 0, 0, 7, 6'h3F);
    arm(16'h0042);
    for (int i = 0; i < 4; i++) push(3, 16'(i), 0);
    wait_rx(4);
    push(3, 16'h0099, 0);
    repeat (200) @(posedge clk);
    rd(2'd1, v);
    chk("R7 stall rx", 32'(v[15:8]), 4);
    chk("R7 stall tx", 32'(v[7:0]), 1);
    rd(2'd3, v); chk("R7 head", v, 32'h42);
    wait_rx(4);
    rd(2'd1, v); chk("R7 resumed tx", 32'(v[7:0]), 0);
    wr(2'd0, ctrl_w(0, 1));
    rd(2'd1, v); chk("R10 rx flushed", 32'(v[15:8]), 0);

    // random frames across modes, lengths and lines (R5 R6 R7 R8)
    for (int it = 0; it < 40; it++) begin
      int fs, cs;
      bit p, h, l;
      logic [15:0] d, s;
      fs = $urandom % 16; cs = $urandom % 8;
      p = 1'($urandom); h = 1'($urandom); l = 1'($urandom);
      d = 16'($urandom); s = 16'($urandom);
      cfg(1, 0, p, h, l, fs, 6'h3F);
      one_frame("R5 R6 random", cs, d, s);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule